// File: doc/BRIEF.md
# Receive byte queue with status registers

This block sits between a serial receiver and a processor register port. Incoming bytes, along with their parity and framing flags and any break events, are placed in a circular byte queue. The processor takes bytes out by reading a data register. Around the queue sit a control register, a queue-level register, a transfer-status register and a sticky error log that clears when read. Two request lines go to a separate interrupt block: one for received data and one for error conditions.

The block has two modes. In queued mode, bytes pass through the queue and the receive request is raised while the fill level is at or above a programmable threshold. In direct mode, a single holding register replaces the queue: each arriving byte overwrites it, and a one-cycle receive request is issued. The transmit side lies outside this block. Its fill level and full flag come in as inputs and appear only in the level register. A transmit flush request leaves as a one-cycle pulse.

Top module: `rxq_status_unit`

## Requirements
- R1: After reset, every register reads zero, both request outputs are low and `tx_flush` is low.
- R2: In queued mode (control bit 0 = 1), data-register reads (address 4) return stored bytes in arrival order. The default capacity is 16 bytes.
- R3: The level register (address 3) shows the receive count in bits [7:0], receive-full in bit 8, `tx_level` in bits [23:16] and `tx_full` in bit 24. While the queue is full, bits [7:0] read 0.
- R4: A byte that arrives while the queue is full, with no read in the same cycle, is discarded. It sets error-log bit 0 and pulses `irq_err_req` in the following cycle.
- R5: A break stores 0x00 (in either mode), sets error-log bit 3 and pulses `irq_err_req`. If `rx_valid` is high in the same cycle, that byte is ignored.
- R6: A byte that carries a parity or framing flag is still stored. It sets error-log bit 1 (parity) or bit 2 (framing) and pulses `irq_err_req`.
- R7: Reading the error log (address 2) returns its value, and the log is then cleared. A bit set in the same cycle as the read stays set.
- R8: Transfer-status (address 1) bit 0 is the data-ready flag. It becomes 1 when a byte is stored and returns to 0 when a read empties the queue.
- R9: In queued mode, a data read while the queue is empty returns 0x00, leaves the count at 0 and pulses `irq_err_req`. The error log is not changed.
- R10: In direct mode (control bit 0 = 0), each byte overwrites the holding register, sets data-ready and pulses `irq_rx_req` for one cycle. A data read returns the holding register and clears data-ready. The queue is left untouched.
- R11: Control (address 0) keeps bit 0, receive threshold [6:4] and transmit threshold [10:8]. Writing bit 1 empties the queue and overrides any byte stored in the same cycle. Writing bit 2 pulses `tx_flush` for one cycle. Bits 1 and 2 always read 0.
- R12: In queued mode, `irq_rx_req` is high exactly while count >= (threshold+1)*DEPTH/8. It updates in the same cycle as the count.
- R13: A byte arriving in the same cycle as a data read is stored, even when the queue is full. The read returns the oldest byte and the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received byte valid this cycle |
| rx_data | input | 8 | Received byte |
| rx_parity_err | input | 1 | Parity error flag for `rx_data` |
| rx_frame_err | input | 1 | Framing error flag for `rx_data` |
| rx_break | input | 1 | Break event this cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 11 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| tx_level | input | 8 | Transmit fill level, reported only |
| tx_full | input | 1 | Transmit full flag, reported only |
| irq_rx_req | output | 1 | Receive interrupt-source request |
| irq_err_req | output | 1 | Error interrupt-source request (one-cycle pulse) |
| tx_flush | output | 1 | One-cycle transmit flush request |

## Verification
A store and a data-register read can happen in the same cycle. This matters most when the queue is full: the incoming byte must be accepted without an overrun, the oldest byte must come out and the count must stay at capacity. The bench fills the queue to 16, presents a new byte together with a data read, and then checks the returned byte, the level register and the error request. It then drains the queue and expects the new byte to come out last. The same pairing is also tested on an empty queue, where the read is an error but the store goes ahead, and a clear-on-read of the error log is tested in the same cycle as a new break.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;

    localparam int BYTE_W = 8;
    localparam int CTRL_W = 11;

    typedef enum logic [2:0] {
        RA_CTRL  = 3'd0,
        RA_XFER  = 3'd1,
        RA_ERR   = 3'd2,
        RA_LEVEL = 3'd3,
        RA_DATA  = 3'd4
    } rxq_addr_e;

    // error log, bit 3 down to bit 0
    typedef struct packed {
        logic brk;
        logic frame;
        logic parity;
        logic overrun;
    } rxq_err_t;

    typedef struct packed {
        logic              fifo_en;
        logic [2:0]        rx_trig;
        logic [2:0]        tx_trig;
        logic [BYTE_W-1:0] hold;
        logic              hold_rdy;
        logic              irq_rx;
        logic              irq_err;
        logic              tx_flush;
    } rxq_top_t;

endpackage

// File: rtl/rxq_ring.sv
`timescale 1ns/1ps
module rxq_ring #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [DW-1:0]                din,
    input  logic                         pop,
    output logic                         push_ok,
    output logic [DW-1:0]                dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ring_t;

    ring_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic pop_ok;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
    endfunction

    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign count = st_q.cnt;
    assign dout  = mem_q[st_q.rp];

    always_comb begin
        pop_ok  = pop && !empty && !flush;
        push_ok = push && !flush && (!full || pop_ok);
        st_d    = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wp = step_ptr(st_q.wp);
            if (pop_ok)  st_d.rp = step_ptr(st_q.rp);
            if (push_ok && !pop_ok)      st_d.cnt = st_q.cnt + CW'(1);
            else if (pop_ok && !push_ok) st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wp] <= din;
    end

    // R2: the level never exceeds capacity
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R4: a store attempt on a full ring with no read leaves it full
    a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> full);

    // R13: a simultaneous store and read keep the level
    a_r13_simul_level: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty && !flush) |=> $stable(st_q.cnt));

endmodule

// File: rtl/rxq_errlog.sv
`timescale 1ns/1ps
module rxq_errlog
    import rxq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  rxq_err_t set,
    input  logic     rd_clr,
    output rxq_err_t value
);
    rxq_err_t log_d, log_q;

    always_comb begin
        log_d = (rd_clr ? rxq_err_t'('0) : log_q) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) log_q <= '0;
        else        log_q <= log_d;
    end

    assign value = log_q;

    // R7: a read with nothing new arriving leaves an empty log
    a_r7_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && set == '0) |=> (value == '0));

    // R7: without a read, logged bits are never lost
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((value & $past(value)) == $past(value)));

endmodule

// File: rtl/rxq_status_unit.sv
`timescale 1ns/1ps
module rxq_status_unit
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid,
    input  logic [7:0]         rx_data,
    input  logic               rx_parity_err,
    input  logic               rx_frame_err,
    input  logic               rx_break,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [2:0]         bus_addr,
    input  logic [CTRL_W-1:0]  bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [7:0]         tx_level,
    input  logic               tx_full,
    output logic               irq_rx_req,
    output logic               irq_err_req,
    output logic               tx_flush
);
    localparam int CW   = $clog2(DEPTH+1);
    localparam int STEP = DEPTH / 8;

    rxq_top_t st_d, st_q;

    logic             wr_ctrl, rd_data, rd_err, rx_flush, in_push;
    logic [BYTE_W-1:0] in_byte;
    logic             ring_push, ring_pop, push_ok;
    logic [BYTE_W-1:0] head;
    logic [CW-1:0]    count;
    logic             full, empty;
    rxq_err_t         err_set, err_val;
    logic [CW-1:0]    thr;
    logic             ready;

    assign wr_ctrl  = bus_wr && (bus_addr == RA_CTRL);
    assign rd_data  = bus_rd && (bus_addr == RA_DATA);
    assign rd_err   = bus_rd && (bus_addr == RA_ERR);
    assign rx_flush = wr_ctrl && bus_wdata[1];
    assign in_push  = rx_valid || rx_break;
    assign in_byte  = rx_break ? '0 : rx_data;

    assign ring_push = st_q.fifo_en && in_push;
    assign ring_pop  = st_q.fifo_en && rd_data;

    rxq_ring #(.DEPTH(DEPTH), .DW(BYTE_W)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (rx_flush),
        .push    (ring_push),
        .din     (in_byte),
        .pop     (ring_pop),
        .push_ok (push_ok),
        .dout    (head),
        .count   (count),
        .full    (full),
        .empty   (empty)
    );

    always_comb begin
        err_set.overrun = ring_push && !push_ok && !rx_flush;
        err_set.parity  = rx_valid && !rx_break && rx_parity_err;
        err_set.frame   = rx_valid && !rx_break && rx_frame_err;
        err_set.brk     = rx_break;
    end

    rxq_errlog u_errlog (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (err_set),
        .rd_clr (rd_err),
        .value  (err_val)
    );

    // next-state
    always_comb begin
        st_d          = st_q;
        st_d.tx_flush = wr_ctrl && bus_wdata[2];
        st_d.irq_err  = (|err_set) || (ring_pop && empty);
        st_d.irq_rx   = !st_q.fifo_en && in_push;
        if (wr_ctrl) begin
            st_d.fifo_en = bus_wdata[0];
            st_d.rx_trig = bus_wdata[6:4];
            st_d.tx_trig = bus_wdata[10:8];
        end
        if (!st_q.fifo_en) begin
            if (in_push) begin
                st_d.hold     = in_byte;
                st_d.hold_rdy = 1'b1;
            end else if (rd_data) begin
                st_d.hold_rdy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign thr         = CW'((32'(st_q.rx_trig) + 32'd1) * STEP);
    assign ready       = st_q.fifo_en ? !empty : st_q.hold_rdy;
    assign irq_rx_req  = st_q.fifo_en ? (count >= thr) : st_q.irq_rx;
    assign irq_err_req = st_q.irq_err;
    assign tx_flush    = st_q.tx_flush;

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_CTRL: begin
                bus_rdata[0]    = st_q.fifo_en;
                bus_rdata[6:4]  = st_q.rx_trig;
                bus_rdata[10:8] = st_q.tx_trig;
            end
            RA_XFER:  bus_rdata[0] = ready;
            RA_ERR:   bus_rdata[3:0] = err_val;
            RA_LEVEL: begin
                bus_rdata[7:0]   = full ? 8'd0 : 8'(count);
                bus_rdata[8]     = full;
                bus_rdata[23:16] = tx_level;
                bus_rdata[24]    = tx_full;
            end
            RA_DATA: begin
                if (st_q.fifo_en) bus_rdata[7:0] = empty ? 8'd0 : head;
                else              bus_rdata[7:0] = st_q.hold;
            end
            default: bus_rdata = '0;
        endcase
    end

    // R9: an empty-queue data read raises the error request next cycle
    a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fifo_en && rd_data && empty) |=> irq_err_req);

    // R11: a receive flush leaves the queue empty
    a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[1]) |=> (count == '0));

    // R10: direct-mode arrival gives a receive request next cycle
    a_r10_direct_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.fifo_en && !wr_ctrl && in_push) |=> irq_rx_req);

    // R5: a break always produces an error request next cycle
    a_r5_break_err: assert property (@(posedge clk) disable iff (!rst_n)
        rx_break |=> irq_err_req);

endmodule

// File: tb/rxq_status_unit_tb.sv
`timescale 1ns/1ps
module rxq_status_unit_tb;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_valid, rx_parity_err, rx_frame_err, rx_break;
    logic [7:0]  rx_data;
    logic        bus_wr, bus_rd;
    logic [2:0]  bus_addr;
    logic [10:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [7:0]  tx_level;
    logic        tx_full;
    logic        irq_rx_req, irq_err_req, tx_flush;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rxq_status_unit #(.DEPTH(DEPTH)) u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FIAL-free? no: FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one cycle of stimulus; called right after a falling edge
    task automatic step(input logic v, input logic [7:0] d, input logic p, input logic fr,
                        input logic brk, input logic rd, input logic wr, input logic [2:0] a,
                        input logic [10:0] wd, output logic [31:0] q);
        rx_valid = v; rx_data = d; rx_parity_err = p; rx_frame_err = fr; rx_break = brk;
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        #1 q = bus_rdata;
        @(negedge clk);
        rx_valid = 0; rx_parity_err = 0; rx_frame_err = 0; rx_break = 0;
        bus_rd = 0; bus_wr = 0;
    endtask

    task automatic push(input logic [7:0] d);
        logic [31:0] q;
        step(1, d, 0, 0, 0, 0, 0, 3'd0, 11'd0, q);
    endtask

    task automatic rdreg(input logic [2:0] a, output logic [31:0] q);
        step(0, 8'd0, 0, 0, 0, 1, 0, a, 11'd0, q);
    endtask

    task automatic wrreg(input logic [2:0] a, input logic [10:0] wd);
        logic [31:0] q;
        step(0, 8'd0, 0, 0, 0, 0, 1, a, wd, q);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] q;
        rx_valid = 0; rx_data = 0; rx_parity_err = 0; rx_frame_err = 0; rx_break = 0;
        bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        tx_level = 0; tx_full = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq_rx", irq_rx_req, 0);
        chk("R1 irq_err", irq_err_req, 0);
        chk("R1 tx_flush", tx_flush, 0);
        for (int a = 0; a < 5; a++) begin
            rdreg(3'(a), q);
            chk("R1 reg", q, 0);
        end

        // sweep of every receive threshold
        for (int f = 0; f < 8; f++) begin
            wrreg(3'd0, 11'(1 | 2 | (f << 4) | (((7 - f)) << 8)));
            rdreg(3'd0, q);
            chk("R11 ctrl readback", q, 32'(1 | (f << 4) | ((7 - f) << 8)));
            for (int n = 1; n <= DEPTH; n++) begin
                push(8'((f * 37 + n * 5) & 255));
                chk("R12 rx request", irq_rx_req, 32'(n >= (f + 1) * (DEPTH / 8)));
                rdreg(3'd3, q);
                chk("R3 level count", q[7:0], (n == DEPTH) ? 0 : n);
                chk("R3 level full", q[8], n == DEPTH);
                rdreg(3'd1, q);
                chk("R8 ready set", q[0], 1);
            end
            push(8'hEE);
            chk("R4 overrun request", irq_err_req, 1);
            rdreg(3'd2, q);
            chk("R4 overrun bit", q, 1);
            rdreg(3'd2, q);
            chk("R7 cleared", q, 0);
            rdreg(3'd3, q);
            chk("R4 still full", q[8:0], 9'h100);
            for (int n = 1; n <= DEPTH; n++) begin
                rdreg(3'd4, q);
                chk("R2 order", q, 32'((f * 37 + n * 5) & 255));
            end
            rdreg(3'd1, q);
            chk("R8 ready cleared", q[0], 0);
            rdreg(3'd4, q);
            chk("R9 empty data", q, 0);
            chk("R9 empty request", irq_err_req, 1);
            rdreg(3'd3, q);
            chk("R9 count zero", q[8:0], 0);
            rdreg(3'd2, q);
            chk("R9 log untouched", q, 0);
        end

        // R13 store and read together at full
        wrreg(3'd0, 11'h003);
        for (int n = 0; n < DEPTH; n++) push(8'(n + 1));
        step(1, 8'hA5, 0, 0, 0, 1, 0, 3'd4, 11'd0, q);
        chk("R13 oldest out", q, 1);
        chk("R13 no error", irq_err_req, 0);
        rdreg(3'd3, q);
        chk("R13 still full", q[8:0], 9'h100);
        for (int n = 2; n <= DEPTH; n++) begin
            rdreg(3'd4, q);
            chk("R13 drain", q, n);
        end
        rdreg(3'd4, q);
        chk("R13 new byte last", q, 32'hA5);

        // R13/R9 store and read together while empty
        step(1, 8'h5A, 0, 0, 0, 1, 0, 3'd4, 11'd0, q);
        chk("R9 empty read value", q, 0);
        chk("R9 empty read request", irq_err_req, 1);
        rdreg(3'd4, q);
        chk("R13 stored", q, 32'h5A);

        // R5 break wins over a byte
        step(1, 8'h77, 0, 0, 1, 0, 0, 3'd0, 11'd0, q);
        chk("R5 break request", irq_err_req, 1);
        rdreg(3'd2, q);
        chk("R5 break bit", q, 8);
        rdreg(3'd4, q);
        chk("R5 null byte", q, 0);
        rdreg(3'd1, q);
        chk("R5 byte ignored", q[0], 0);

        // R6 parity and framing
        step(1, 8'h3C, 1, 0, 0, 0, 0, 3'd0, 11'd0, q);
        chk("R6 parity request", irq_err_req, 1);
        step(1, 8'hC3, 0, 1, 0, 0, 0, 3'd0, 11'd0, q);
        rdreg(3'd2, q);
        chk("R6 log bits", q, 6);
        rdreg(3'd4, q);
        chk("R6 parity byte kept", q, 32'h3C);
        rdreg(3'd4, q);
        chk("R6 frame byte kept", q, 32'hC3);

        // R7 set during clear-on-read survives
        push(8'h10);
        step(1, 8'h10, 1, 0, 0, 0, 0, 3'd0, 11'd0, q);
        step(0, 8'h00, 0, 0, 1, 1, 0, 3'd2, 11'd0, q);
        chk("R7 read value", q, 2);
        rdreg(3'd2, q);
        chk("R7 new bit kept", q, 8);

        // R11 flush overrides a same-cycle store, tx flush pulse
        step(1, 8'h99, 0, 0, 0, 0, 1, 3'd0, 11'h007, q);
        chk("R11 tx flush pulse", tx_flush, 1);
        rdreg(3'd3, q);
        chk("R11 queue emptied", q[8:0], 0);
        chk("R11 tx flush ends", tx_flush, 0);
        rdreg(3'd0, q);
        chk("R11 self clear", q, 1);

        // R10 direct mode
        wrreg(3'd0, 11'h000);
        push(8'h11);
        chk("R10 rx pulse", irq_rx_req, 1);
        push(8'h22);
        rdreg(3'd1, q);
        chk("R10 pulse ends", irq_rx_req, 0);
        chk("R10 ready", q[0], 1);
        rdreg(3'd4, q);
        chk("R10 overwrite", q, 32'h22);
        rdreg(3'd1, q);
        chk("R10 ready cleared", q[0], 0);
        rdreg(3'd3, q);
        chk("R10 queue untouched", q[8:0], 0);
        step(0, 8'h00, 0, 0, 1, 0, 0, 3'd0, 11'd0, q);
        rdreg(3'd4, q);
        chk("R5 direct break byte", q, 0);

        // R3 transmit reporting
        for (int t = 0; t < 4; t++) begin
            tx_level = 8'(t * 61);
            tx_full = t[0];
            rdreg(3'd3, q);
            chk("R3 tx fields", q, 32'((t * 61) << 16) | (32'(t[0]) << 24));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule